// File: doc/BRIEF.md
# Nanosecond Real-Time Clock with One-Shot Alarm

This peripheral keeps a 64-bit time value in nanoseconds. The value moves forward by a fixed step on every clock cycle in which the `tick_i` input is high. Software reaches the block through one 32-bit slave port: a valid/write/address/data request, with read data returned one clock later. Software can read the time as two 32-bit halves and overwrite either half. It can also load a 64-bit alarm compare value, arm it, cancel it, and manage a single level-sensitive interrupt.

Internally the time is the sum of a free-running counter and a 64-bit offset. A write to one time half changes only the offset, so the counter itself is never reloaded. The alarm is armed only by a write to its low word, so software writes the high word first. From then on the alarm is compared against the time on every cycle with greater-or-equal. Its pending flag is combined with an enable bit to drive the interrupt line.

Register word offsets (byte address, 32-bit aligned): 0x00 time[31:0], 0x04 time[63:32], 0x08 alarm[31:0], 0x0C alarm[63:32], 0x10 interrupt enable (bit 0), 0x14 cancel alarm (write only), 0x18 alarm running flag (bit 0, read only), 0x1C clear pending (write only).

Top module: `ns_rtc`

## Requirements
- R1: After reset the time, the alarm compare value, the running flag, the pending flag and the enable bit all read 0, and `irq_o` is 0.
- R2: Each cycle with `tick_i` high adds STEP (default 1) to the 64-bit time, and a carry out of the low half propagates into the high half.
- R3: A write to 0x00 or 0x04 replaces only that 32-bit half of the time, and the other half keeps the value it had at the moment of the write.
- R4: A write to 0x0C stores alarm[63:32], reads back at 0x0C, and neither arms nor cancels the alarm.
- R5: A write to 0x08 stores alarm[31:0] and arms the alarm. If the compare value is later than the current time, the running flag (0x18 bit 0) becomes 1 and the pending flag stays unchanged.
- R6: While the alarm is running and the time is greater than or equal to the compare value, the next clock edge clears the running flag and sets the pending flag.
- R7: Arming with a compare value at or before the current time sets the pending flag at once, on the edge of the write, and leaves the running flag at 0.
- R8: `irq_o` is 1 exactly when both the pending flag and the enable bit are 1. A write to 0x10 loads the enable from bit 0, and a read of 0x10 returns it in bit 0.
- R9: A write to 0x14 clears the running flag, so the alarm cannot fire later, and it leaves the pending flag unchanged.
- R10: A write to 0x1C clears the pending flag. If the alarm fires in the same cycle, the set wins.
- R11: Reads of 0x14, 0x1C, unmapped offsets and addresses that are not word-aligned return 0. Writes to 0x18, to unmapped offsets and to unaligned addresses change nothing.
- R12: A time write that moves the time to or past a running alarm's compare value fires the alarm on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Advance the time by STEP in this cycle |
| bus_valid_i | input | 1 | Request valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Level interrupt (pending AND enable) |

## Verification
A write takes effect on the clock edge that accepts it. Reads of time and flags therefore see the new value from the next request on, and `irq_o` changes right after that same edge when the write sets or clears pending or enable directly. Read data is registered, so it is sampled on the falling edge after the edge that accepted the request. An alarm that a tick or a time write brings into range fires one edge later than the time update, so the bench waits one extra falling edge before it samples `irq_o`. Every stimulus is driven and every output sampled on falling edges, which keeps each check on the cycle in which its result is due.

// File: rtl/ns_rtc_pkg.sv
package ns_rtc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 2 * WORD_W;
  localparam int unsigned NUM_REGS = 8;

  typedef enum logic [2:0] {
    RG_TLO  = 3'd0,
    RG_THI  = 3'd1,
    RG_ALO  = 3'd2,
    RG_AHI  = 3'd3,
    RG_IEN  = 3'd4,
    RG_CALM = 3'd5,
    RG_STAT = 3'd6,
    RG_CINT = 3'd7
  } reg_sel_e;

  // Replace one 32-bit half of a 64-bit value.
  function automatic logic [TIME_W-1:0] f_splice(input logic [TIME_W-1:0] cur,
                                                 input logic [WORD_W-1:0] word,
                                                 input logic upper);
    logic [TIME_W-1:0] r;
    r = cur;
    if (upper) r[TIME_W-1:WORD_W] = word;
    else       r[WORD_W-1:0]      = word;
    return r;
  endfunction

  // Offset that makes free + offset equal the target.
  function automatic logic [TIME_W-1:0] f_offset(input logic [TIME_W-1:0] target,
                                                 input logic [TIME_W-1:0] free_cnt);
    return target - free_cnt;
  endfunction
endpackage

// File: rtl/ns_rtc_decode.sv
module ns_rtc_decode
  import ns_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             mapped;

  assign idx      = addr_i[ADDR_W-1:2];
  assign mapped   = (addr_i[1:0] == 2'b00) && (int'(idx) < NUM_REGS);
  assign sel_o    = reg_sel_e'(idx[2:0]);
  assign wr_hit_o = valid_i && write_i && mapped;
  assign rd_hit_o = valid_i && !write_i && mapped;
endmodule

// File: rtl/ns_rtc_count.sv
module ns_rtc_count
  import ns_rtc_pkg::*;
#(
  parameter logic [63:0] STEP = 64'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [TIME_W-1:0] now_o
);
  logic [TIME_W-1:0] free_q;
  logic [TIME_W-1:0] off_q;
  logic [TIME_W-1:0] target;
  logic              time_wr;

  assign now_o   = free_q + off_q;
  assign target  = f_splice(now_o, wdata_i, wr_hi_i);
  assign time_wr = wr_lo_i || wr_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '0;
      off_q  <= '0;
    end else begin
      if (tick_i)  free_q <= free_q + STEP;
      if (time_wr) off_q  <= f_offset(target, free_q);
    end
  end

  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !time_wr) |=> now_o == $past(now_o) + STEP);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !time_wr) |=> $stable(now_o));

  a_r3_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && !tick_i) |=> now_o == {$past(now_o[TIME_W-1:WORD_W]), $past(wdata_i)});

  a_r3_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && !tick_i) |=> now_o == {$past(wdata_i), $past(now_o[WORD_W-1:0])});
endmodule

// File: rtl/ns_rtc_alarm.sv
module ns_rtc_alarm
  import ns_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              wr_alo_i,
  input  logic              wr_ahi_i,
  input  logic              wr_calm_i,
  input  logic              wr_cint_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [TIME_W-1:0] cmp_o,
  output logic              run_o,
  output logic              pend_o
);
  logic [TIME_W-1:0] cmp_q;
  logic              run_q;
  logic              pend_q;
  logic [TIME_W-1:0] arm_val;
  logic              arm_future;
  logic              reach;
  logic              set_pend;

  assign arm_val    = f_splice(cmp_q, wdata_i, 1'b0);
  assign arm_future = arm_val > now_i;
  assign reach      = run_q && (now_i >= cmp_q);
  assign set_pend   = (wr_alo_i && !arm_future) ||
                      (!wr_alo_i && !wr_calm_i && reach);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_alo_i)      cmp_q <= arm_val;
      else if (wr_ahi_i) cmp_q <= f_splice(cmp_q, wdata_i, 1'b1);

      if (wr_alo_i)                  run_q <= arm_future;
      else if (wr_calm_i || reach)   run_q <= 1'b0;

      if (set_pend)       pend_q <= 1'b1;
      else if (wr_cint_i) pend_q <= 1'b0;
    end
  end

  assign cmp_o  = cmp_q;
  assign run_o  = run_q;
  assign pend_o = pend_q;

  a_r4_high_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ahi_i && !reach) |=> $stable(run_q));

  a_r5_arm_future: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alo_i && arm_future) |=> run_q && $stable(pend_q));

  a_r6_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (now_i >= cmp_q) && !wr_alo_i && !wr_calm_i) |=> pend_q && !run_q);

  a_r7_late_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alo_i && (arm_val <= now_i)) |=> pend_q && !run_q);

  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_calm_i |=> !run_q && $stable(pend_q));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cint_i && !set_pend) |=> !pend_q);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cint_i && set_pend) |=> pend_q);
endmodule

// File: rtl/ns_rtc.sv
module ns_rtc
  import ns_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter logic [63:0] STEP   = 64'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  reg_sel_e            sel;
  logic                wr_hit;
  logic                rd_hit;
  logic [NUM_REGS-1:0] wr_vec;
  logic [TIME_W-1:0]   now;
  logic [TIME_W-1:0]   cmp;
  logic                run;
  logic                pend;
  logic                en_q;
  logic [WORD_W-1:0]   rd_mux;
  logic [WORD_W-1:0]   rdata_q;

  ns_rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i (bus_valid_i),
    .write_i (bus_write_i),
    .addr_i  (bus_addr_i),
    .sel_o   (sel),
    .wr_hit_o(wr_hit),
    .rd_hit_o(rd_hit)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr
    assign wr_vec[g] = wr_hit && (sel == reg_sel_e'(g));
  end

  ns_rtc_count #(.STEP(STEP)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .wr_lo_i(wr_vec[RG_TLO]),
    .wr_hi_i(wr_vec[RG_THI]),
    .wdata_i(bus_wdata_i),
    .now_o  (now)
  );

  ns_rtc_alarm u_alm (
    .clk      (clk),
    .rst_n    (rst_n),
    .now_i    (now),
    .wr_alo_i (wr_vec[RG_ALO]),
    .wr_ahi_i (wr_vec[RG_AHI]),
    .wr_calm_i(wr_vec[RG_CALM]),
    .wr_cint_i(wr_vec[RG_CINT]),
    .wdata_i  (bus_wdata_i),
    .cmp_o    (cmp),
    .run_o    (run),
    .pend_o   (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (wr_vec[RG_IEN]) en_q <= bus_wdata_i[0];
  end

  always_comb begin
    rd_mux = '0;
    if (rd_hit) begin
      case (sel)
        RG_TLO:  rd_mux = now[WORD_W-1:0];
        RG_THI:  rd_mux = now[TIME_W-1:WORD_W];
        RG_ALO:  rd_mux = cmp[WORD_W-1:0];
        RG_AHI:  rd_mux = cmp[TIME_W-1:WORD_W];
        RG_IEN:  rd_mux = {{(WORD_W-1){1'b0}}, en_q};
        RG_STAT: rd_mux = {{(WORD_W-1){1'b0}}, run};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_valid_i && !bus_write_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = pend && en_q;

  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vec[RG_IEN] && !bus_wdata_i[0]) |=> !irq_o);

  a_r8_enable_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vec[RG_IEN] && bus_wdata_i[0] && pend && !wr_vec[RG_CINT]) |=> irq_o);

  a_r11_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  a_r11_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_write_i && !rd_hit) |=> bus_rdata_o == '0);
endmodule

// File: tb/ns_rtc_tb_top.sv
`timescale 1ns/1ps
module ns_rtc_tb_top;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          valid = 1'b0;
  logic          write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [63:0] exp_t = 64'd0;

  always #2 clk = ~clk;

  ns_rtc #(.ADDR_W(AW), .STEP(64'd1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    exp_t = exp_t + 64'(n);
  endtask

  task automatic chk_time(input string req);
    logic [31:0] v;
    rd(6'h00, v); check(req, {32'd0, v}, {32'd0, exp_t[31:0]});
    rd(6'h04, v); check(req, {32'd0, v}, {32'd0, exp_t[63:32]});
  endtask

  task automatic chk_rd(input string req, input logic [AW-1:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    check(req, {32'd0, v}, {32'd0, e});
  endtask

  task automatic t_reset();
    check("R1 irq", {63'd0, irq}, 64'd0);
    chk_time("R1 time");
    chk_rd("R1 alarm lo", 6'h08, 32'd0);
    chk_rd("R1 alarm hi", 6'h0C, 32'd0);
    chk_rd("R1 enable", 6'h10, 32'd0);
    chk_rd("R1 running", 6'h18, 32'd0);
  endtask

  task automatic t_tick_and_time_write();
    ticks(10);
    chk_time("R2 ten ticks");
    wr(6'h00, 32'hFFFF_FFF0);
    exp_t = {exp_t[63:32], 32'hFFFF_FFF0};
    chk_time("R3 low write");
    ticks(20);
    chk_time("R2 carry");
    wr(6'h04, 32'h1234_5678);
    exp_t = {32'h1234_5678, exp_t[31:0]};
    chk_time("R3 high write");
  endtask

  task automatic t_unmapped();
    chk_rd("R11 read cancel", 6'h14, 32'd0);
    chk_rd("R11 read clear", 6'h1C, 32'd0);
    chk_rd("R11 read unmapped", 6'h20, 32'd0);
    chk_rd("R11 read unaligned", 6'h01, 32'd0);
    wr(6'h18, 32'd1);
    chk_rd("R11 status write ignored", 6'h18, 32'd0);
    wr(6'h11, 32'd1);
    chk_rd("R11 unaligned write ignored", 6'h10, 32'd0);
    wr(6'h24, 32'hFFFF_FFFF);
    chk_time("R11 unmapped write ignored");
  endtask

  task automatic t_arm_and_fire();
    wr(6'h0C, 32'h1234_5678);
    chk_rd("R4 high readback", 6'h0C, 32'h1234_5678);
    chk_rd("R4 high no arm", 6'h18, 32'd0);
    wr(6'h08, 32'h0000_0010);
    chk_rd("R5 running", 6'h18, 32'd1);
    chk_rd("R5 low readback", 6'h08, 32'h10);
    wr(6'h10, 32'd1);
    check("R5 no pending", {63'd0, irq}, 64'd0);
    ticks(11);
    @(negedge clk);
    check("R6 not yet", {63'd0, irq}, 64'd0);
    chk_rd("R6 still running", 6'h18, 32'd1);
    ticks(1);
    @(negedge clk);
    check("R6 fired", {63'd0, irq}, 64'd1);
    chk_rd("R6 running cleared", 6'h18, 32'd0);
    wr(6'h1C, 32'd0);
    check("R10 cleared", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_late_arm();
    wr(6'h08, 32'h0000_0005);
    check("R7 past fires", {63'd0, irq}, 64'd1);
    chk_rd("R7 not running", 6'h18, 32'd0);
    wr(6'h1C, 32'd0);
    wr(6'h08, exp_t[31:0]);
    check("R7 equal fires", {63'd0, irq}, 64'd1);
  endtask

  task automatic t_enable();
    wr(6'h10, 32'd0);
    check("R8 masked", {63'd0, irq}, 64'd0);
    chk_rd("R8 enable 0", 6'h10, 32'd0);
    wr(6'h10, 32'd3);
    check("R8 unmasked", {63'd0, irq}, 64'd1);
    chk_rd("R8 enable 1", 6'h10, 32'd1);
  endtask

  task automatic t_cancel();
    wr(6'h08, 32'h0000_0100);
    chk_rd("R5 armed again", 6'h18, 32'd1);
    check("R5 pending kept", {63'd0, irq}, 64'd1);
    wr(6'h14, 32'd0);
    chk_rd("R9 cancelled", 6'h18, 32'd0);
    check("R9 pending kept", {63'd0, irq}, 64'd1);
    wr(6'h1C, 32'd0);
    ticks(256);
    @(negedge clk);
    check("R9 no late fire", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_jump();
    wr(6'h08, 32'h0000_0200);
    chk_rd("R5 armed for jump", 6'h18, 32'd1);
    wr(6'h04, 32'h1234_5679);
    exp_t = {32'h1234_5679, exp_t[31:0]};
    @(negedge clk);
    check("R12 jump fires", {63'd0, irq}, 64'd1);
    chk_rd("R12 running cleared", 6'h18, 32'd0);
    chk_time("R3 after jump");
  endtask

  task automatic t_set_wins();
    wr(6'h1C, 32'd0);
    wr(6'h0C, 32'h1234_5679);
    wr(6'h08, exp_t[31:0] + 32'd1);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    exp_t = exp_t + 64'd1;
    valid = 1'b1; write = 1'b1; addr = 6'h1C; wdata = 32'd0;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    check("R10 set wins", {63'd0, irq}, 64'd1);
    wr(6'h1C, 32'd0);
    check("R10 cleared after", {63'd0, irq}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tick_and_time_write();
    t_unmapped();
    t_arm_and_fire();
    t_late_arm();
    t_enable();
    t_cancel();
    t_jump();
    t_set_wins();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule